// File: doc/BRIEF.md
# Security Attribution Region Register File

This block is the configuration store of a security attribution unit. It holds a global control word, a read-only word that reports how many regions were built, a region selector, and one base word and one limit word per region. The region words are not mapped one by one. Software first writes the selector, and then reaches the chosen entry through a single base window and a single limit window. The block only stores values and returns them. Address lookup and fault reporting belong to other logic.

Every access carries a secure attribute. Non-secure traffic sees all five registers as zero and cannot change them. When the security extension is configured off, or when the address is outside the five-word window, the access gets an error response. A request is answered exactly one cycle later with a registered response.

Top module: `secattr_regbank`

## Requirements
- R1: The registers sit at byte offsets 0xDD0 (control), 0xDD4 (region count), 0xDD8 (selector), 0xDDC (region base) and 0xDE0 (region limit). A secure read of each offset returns that register.
- R2: A non-secure read of any of the five offsets returns zero with no error. A non-secure write to them leaves all stored state unchanged.
- R3: A control write stores only wdata bits [1:0]. Bits [31:2] read back as zero.
- R4: The count register returns NUM_REGIONS in bits [7:0] and zero above. Writes to it complete without error and have no effect.
- R5: A selector write with a value at or above NUM_REGIONS is dropped, and the previous selector value is kept.
- R6: Base and limit accesses act on the entry named by the selector. Entries are independent. When the selector is not below NUM_REGIONS (always the case for NUM_REGIONS = 0), reads return zero and writes are dropped.
- R7: A base write stores wdata with bits [4:0] cleared.
- R8: A limit write stores wdata with bits [4:2] cleared, keeping bits [1:0] and [31:5].
- R9: A synchronous active-high reset clears the control word, the selector and every base and limit entry.
- R10: With SEC_EXT = 0, any access to the five offsets returns an error with zero data.
- R11: An access to any offset outside the five-word window returns an error with zero data.
- R12: For each request cycle, rspValid is high in the following cycle, and only then.
- R13: NUM_REGIONS above 255 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busReq | input | 1 | Access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | 32 | Write data |
| busSecure | input | 1 | Access carries the secure attribute |
| rspValid | output | 1 | Response valid (one cycle after request) |
| rspErr | output | 1 | Error response |
| rspRdata | output | 32 | Read data (zero on error or non-secure) |

## Verification
The hardest state to reach is a selector that points past the implemented regions. A correctly built bank never accepts such a value, so it cannot be produced from the ports of the main instance. The bench therefore adds a zero-region instance on the same bus. In that instance the reset selector of zero is already out of range, so the dropped base and limit accesses can be seen there. A third instance, built with the extension disabled, shares the same stimulus and shows the error path on the mapped offsets.

// File: rtl/secattr_pkg.sv
package secattr_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;
  localparam logic [OFF_W-1:0] OFF_CTRL = 12'hDD0;
  localparam logic [OFF_W-1:0] OFF_TYPE = 12'hDD4;
  localparam logic [OFF_W-1:0] OFF_RNR  = 12'hDD8;
  localparam logic [OFF_W-1:0] OFF_RBAR = 12'hDDC;
  localparam logic [OFF_W-1:0] OFF_RLAR = 12'hDE0;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0000_0003;
  localparam logic [DATA_W-1:0] BASE_KEEP = 32'hFFFF_FFE0;
  localparam logic [DATA_W-1:0] LIM_KEEP  = 32'hFFFF_FFE3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_RNR, SEL_RBAR, SEL_RLAR
  } regSel_e;

  typedef struct packed {
    logic    req;
    logic    err;
    logic    wrEn;
    logic    rdZero;
    regSel_e sel;
  } strobe_t;
endpackage

// File: rtl/secattr_ctrl.sv
module secattr_ctrl
  import secattr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit SEC_EXT = 1'b1
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSecure,
  output strobe_t           stb
);
  localparam int HI_W = (ADDR_W > OFF_W) ? ADDR_W - OFF_W : 1;

  regSel_e decSel;
  logic    upperZero;
  logic    inWindow;

  generate
    if (ADDR_W > OFF_W) begin : g_upper
      assign upperZero = (busAddr[ADDR_W-1:OFF_W] == '0);
    end else begin : g_noupper
      assign upperZero = 1'b1;
    end
  endgenerate

  always_comb begin
    decSel = SEL_NONE;
    if (upperZero) begin
      unique case (busAddr[OFF_W-1:0])
        OFF_CTRL: decSel = SEL_CTRL;
        OFF_TYPE: decSel = SEL_TYPE;
        OFF_RNR:  decSel = SEL_RNR;
        OFF_RBAR: decSel = SEL_RBAR;
        OFF_RLAR: decSel = SEL_RLAR;
        default:  decSel = SEL_NONE;
      endcase
    end
  end

  assign inWindow = (decSel != SEL_NONE);

  always_comb begin
    stb.req    = busReq;
    stb.err    = busReq && (!inWindow || !SEC_EXT);
    stb.wrEn   = busReq && busWe && inWindow && SEC_EXT && busSecure;
    stb.rdZero = !busSecure || !inWindow || !SEC_EXT;
    stb.sel    = (SEC_EXT && inWindow) ? decSel : SEL_NONE;
  end

  logic unusedHi;
  assign unusedHi = ^HI_W;
endmodule

// File: rtl/secattr_dp.sv
module secattr_dp
  import secattr_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int ARR_N = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;
  localparam int IDX_W = (ARR_N > 1) ? $clog2(ARR_N) : 1;
  localparam logic [7:0] COUNT8 = 8'(NUM_REGIONS);

  logic [DATA_W-1:0] ctrlReg;
  logic [7:0]        rnrReg;
  logic [DATA_W-1:0] baseArr [ARR_N];
  logic [DATA_W-1:0] limArr  [ARR_N];
  logic              rnrOk;
  logic [IDX_W-1:0]  idx;
  logic              newRnrOk;
  logic [DATA_W-1:0] rdMux;

  assign rnrOk    = ({24'd0, rnrReg} < 32'(NUM_REGIONS));
  assign idx      = rnrReg[IDX_W-1:0];
  assign newRnrOk = (busWdata < 32'(NUM_REGIONS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      rnrReg  <= '0;
      for (int i = 0; i < ARR_N; i++) begin
        baseArr[i] <= '0;
        limArr[i]  <= '0;
      end
    end else if (stb.wrEn) begin
      unique case (stb.sel)
        SEL_CTRL: ctrlReg <= busWdata & CTRL_KEEP;
        SEL_RNR:  if (newRnrOk) rnrReg <= busWdata[7:0];
        SEL_RBAR: if (rnrOk) baseArr[idx] <= busWdata & BASE_KEEP;
        SEL_RLAR: if (rnrOk) limArr[idx]  <= busWdata & LIM_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (stb.sel)
      SEL_CTRL: rdMux = ctrlReg;
      SEL_TYPE: rdMux = {24'd0, COUNT8};
      SEL_RNR:  rdMux = {24'd0, rnrReg};
      SEL_RBAR: rdMux = rnrOk ? baseArr[idx] : '0;
      SEL_RLAR: rdMux = rnrOk ? limArr[idx] : '0;
      default:  rdMux = '0;
    endcase
    if (stb.rdZero) rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= stb.req;
      rspErr   <= stb.err;
      rspRdata <= stb.req ? rdMux : '0;
    end
  end

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ctrlReg[DATA_W-1:2] == '0);
  assert_sel_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (NUM_REGIONS > 0) |-> rnrOk);
  assert_base_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    rnrOk |-> (baseArr[idx][4:0] == 5'd0));
  assert_limit_mid_clear_R8: assert property (@(posedge clk) disable iff (rst)
    rnrOk |-> (limArr[idx][4:2] == 3'd0));
  assert_nonsecure_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    (stb.req && stb.rdZero) |=> ($stable(ctrlReg) && $stable(rnrReg)));
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (ctrlReg == '0 && rnrReg == '0));
  assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> (rspRdata == '0));
endmodule

// File: rtl/secattr_regbank.sv
module secattr_regbank
  import secattr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 8,
  parameter bit SEC_EXT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busSecure,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata
);
  generate
    if (NUM_REGIONS > 255 || NUM_REGIONS < 0) begin : g_badcount
      $error("NUM_REGIONS out of range (R13)");
    end
  endgenerate

  strobe_t stb;

  secattr_ctrl #(.ADDR_W(ADDR_W), .SEC_EXT(SEC_EXT)) u_ctrl (
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busSecure(busSecure), .stb(stb)
  );

  secattr_dp #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .busWdata(busWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
  );

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
    busReq |=> rspValid);
  assert_no_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !busReq |=> !rspValid);
  assert_outside_err_R11: assert property (@(posedge clk) disable iff (rst)
    (busReq && busAddr == '0) |=> rspErr);
endmodule

// File: tb/secattr_regbank_tb.sv
module secattr_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busReq = 1'b0, busWe = 1'b0, busSecure = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        vA, eA, vN, eN, vZ, eZ;
  logic [31:0] dA, dN, dZ;
  logic        gvA, geA, geN, geZ;
  logic [31:0] gdA, gdN, gdZ;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  secattr_regbank u_dut (.clk(clk), .rst(rst), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busSecure(busSecure),
    .rspValid(vA), .rspErr(eA), .rspRdata(dA));
  secattr_regbank #(.SEC_EXT(1'b0)) u_nosec (.clk(clk), .rst(rst), .busReq(busReq),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busSecure(busSecure),
    .rspValid(vN), .rspErr(eN), .rspRdata(dN));
  secattr_regbank #(.NUM_REGIONS(0)) u_zero (.clk(clk), .rst(rst), .busReq(busReq),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busSecure(busSecure),
    .rspValid(vZ), .rspErr(eZ), .rspRdata(dZ));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic access(logic [11:0] a, logic we, logic [31:0] d, logic sec);
    @(negedge clk);
    busReq = 1'b1; busWe = we; busAddr = a; busWdata = d; busSecure = sec;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
    gvA = vA; geA = eA; gdA = dA; geN = eN; gdN = dN; geZ = eZ; gdZ = dZ;
  endtask

  task automatic rd(logic [11:0] a, logic sec);
    access(a, 1'b0, 32'h0, sec);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic testReset();
    rd(12'hDD0, 1); check("R9 ctrl", gdA, 0);
    rd(12'hDD8, 1); check("R9 rnr", gdA, 0);
    rd(12'hDDC, 1); check("R9 base", gdA, 0);
    rd(12'hDE0, 1); check("R9 limit", gdA, 0);
    check("R12 valid", {31'd0, gvA}, 1);
    @(negedge clk); check("R12 idle", {31'd0, vA}, 0);
  endtask

  task automatic testType();
    rd(12'hDD4, 1); check("R4 count", gdA, 8); check("R1 noerr", {31'd0, geA}, 0);
    access(12'hDD4, 1, 32'hFFFF_FFFF, 1); check("R4 wr noerr", {31'd0, geA}, 0);
    rd(12'hDD4, 1); check("R4 after wr", gdA, 8);
  endtask

  task automatic testCtrl();
    access(12'hDD0, 1, 32'hFFFF_FFFF, 1);
    rd(12'hDD0, 1); check("R3 mask", gdA, 3);
    access(12'hDD0, 1, 32'h0000_0006, 1);
    rd(12'hDD0, 1); check("R3 bit2 drop", gdA, 2);
    access(12'hDD0, 1, 32'h3, 1);
  endtask

  task automatic testNonSecure();
    rd(12'hDD0, 0); check("R2 ns read", gdA, 0); check("R2 ns noerr", {31'd0, geA}, 0);
    rd(12'hDD4, 0); check("R2 ns type", gdA, 0);
    access(12'hDD0, 1, 32'h0, 0);
    rd(12'hDD0, 1); check("R2 ns wr ctrl", gdA, 3);
    access(12'hDD8, 1, 32'h5, 0);
    rd(12'hDD8, 1); check("R2 ns wr rnr", gdA, 0);
  endtask

  task automatic testSelector();
    access(12'hDD8, 1, 32'h2, 1); rd(12'hDD8, 1); check("R5 set", gdA, 2);
    access(12'hDD8, 1, 32'h8, 1); rd(12'hDD8, 1); check("R5 at count", gdA, 2);
    access(12'hDD8, 1, 32'h1_0001, 1); rd(12'hDD8, 1); check("R5 wide", gdA, 2);
    access(12'hDD8, 1, 32'h7, 1); rd(12'hDD8, 1); check("R5 top", gdA, 7);
  endtask

  task automatic testRegions();
    access(12'hDD8, 1, 32'h2, 1);
    access(12'hDDC, 1, 32'hFFFF_FFFF, 1);
    rd(12'hDDC, 1); check("R7 base mask", gdA, 32'hFFFF_FFE0);
    access(12'hDE0, 1, 32'hFFFF_FFFF, 1);
    rd(12'hDE0, 1); check("R8 limit mask", gdA, 32'hFFFF_FFE3);
    access(12'hDD8, 1, 32'h3, 1);
    rd(12'hDDC, 1); check("R6 other entry", gdA, 0);
    access(12'hDDC, 1, 32'h1234_5678, 1);
    rd(12'hDDC, 1); check("R7 pattern", gdA, 32'h1234_5660);
    access(12'hDE0, 1, 32'h0000_001F, 1);
    rd(12'hDE0, 1); check("R8 low kept", gdA, 32'h3);
    access(12'hDD8, 1, 32'h2, 1);
    rd(12'hDDC, 1); check("R6 entry kept", gdA, 32'hFFFF_FFE0);
    rd(12'hDE0, 0); check("R2 ns limit", gdA, 0);
  endtask

  task automatic testErrors();
    rd(12'h000, 1); check("R11 low err", {31'd0, geA}, 1); check("R11 data", gdA, 0);
    check("R12 err valid", {31'd0, gvA}, 1);
    rd(12'hDE4, 1); check("R11 next err", {31'd0, geA}, 1);
    rd(12'hDD0, 1); check("R10 nosec err", {31'd0, geN}, 1); check("R10 data", gdN, 0);
    check("R1 main noerr", {31'd0, geA}, 0);
  endtask

  task automatic testZero();
    access(12'hDD8, 1, 32'h0, 1); rd(12'hDD8, 1); check("R6 zero rnr", gdZ, 0);
    access(12'hDDC, 1, 32'hFFFF_FFFF, 1);
    rd(12'hDDC, 1); check("R6 zero base", gdZ, 0); check("R6 zero noerr", {31'd0, geZ}, 0);
    access(12'hDE0, 1, 32'hFFFF_FFFF, 1);
    rd(12'hDE0, 1); check("R6 zero limit", gdZ, 0);
    rd(12'hDD4, 1); check("R4 zero count", gdZ, 0);
  endtask

  task automatic testReReset();
    doReset();
    rd(12'hDD0, 1); check("R9 ctrl again", gdA, 0);
    rd(12'hDD8, 1); check("R9 rnr again", gdA, 0);
    access(12'hDD8, 1, 32'h2, 1);
    rd(12'hDDC, 1); check("R9 entry cleared", gdA, 0);
  endtask

  initial begin
    doReset();
    testReset();
    testType();
    testCtrl();
    testNonSecure();
    testSelector();
    testRegions();
    testErrors();
    testZero();
    testReReset();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule